// File: doc/BRIEF.md
# External Memory Bus Cycle Sequencer

This block turns the memory requests of an 8-bit controller core into the strobe pattern of a multiplexed external bus. One 8-bit bus carries the low address byte and then the data. A separate 8-bit port carries the high address byte. An address-latch strobe (`ale`) is high while the low address is valid. An external latch captures that address when `ale` falls. Code bytes are read with the active-low program strobe (`psen_n`). Data bytes are read with `rd_n` and written with `wr_n`.

A machine cycle has two halves of equal length. At the start of each half the block gives the address-latch strobe a slot. In idle and fetch cycles that strobe pulses twice per machine cycle. A fetch cycle reads two code bytes, one in each half, at the request address and the address after it. A data read or write uses the whole machine cycle. In such a cycle the second latch pulse and both program-strobe pulses are left out. `mc_last` marks the final clock of each machine cycle. The request inputs, the speed selection and the returned `done`/`rdata` are all tied to the machine cycle.

Top module: `ext_bus_seq`

## Requirements
- R1: A machine cycle lasts 12 clocks when `fast_mode` has been latched low and 6 clocks when it has been latched high. `mc_last` is high only in the final clock of each machine cycle.
- R2: `fast_mode` is latched only in the last clock of a machine cycle. A change in the middle of a cycle leaves the length of the current cycle unchanged.
- R3: In idle and fetch cycles `ale` is high for the first 2 clocks (slow) or 1 clock (fast) of each half. That gives two pulses per machine cycle. `psen_n`, `rd_n` and `wr_n` stay high in idle cycles.
- R4: A fetch cycle (`req_kind` = 1) drives `psen_n` low in each half, from the clock after the address hold until the end of the half. Half 0 reads address A and half 1 reads A+1, and the high byte follows each address. `done` pulses in the clock after each half ends, with the byte sampled in the last low clock of `psen_n`.
- R5: In a data cycle (`req_kind` = 2 or 3) there is only the half-0 `ale` pulse, and `psen_n` stays high for the whole cycle.
- R6: A data read (`req_kind` = 2) holds `rd_n` low from the clock after the address hold in half 0 until the second-to-last clock of half 1. It captures `ad_in` at the last low clock. `rdata` is valid and `done` pulses in the final clock of the cycle.
- R7: A data write (`req_kind` = 3) holds `wr_n` low over the same window. It drives the write byte with `ad_oe` high from the clock after the address hold until one clock after `wr_n` rises. `done` pulses in the clock in which `wr_n` rises.
- R8: In every clock where `ale` is high, and in the one clock after it falls, `ad_out` carries the low byte of the current address with `ad_oe` high. `addr_hi` carries the high byte of the current address for the whole half.
- R9: While `ale_off` is 1, `ale` stays low. The other strobes are unaffected.
- R10: After reset the block runs idle slow cycles. `rd_n`, `wr_n` and `psen_n` are high, `done` is low and `rdata` is 0.
- R11: A request is sampled only in the clock where `mc_last` is high. A request that is withdrawn before that clock has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fast_mode | input | 1 | 1 selects 6 clocks per machine cycle |
| ale_off | input | 1 | 1 suppresses address-latch pulses |
| req_valid | input | 1 | Request present, sampled when `mc_last` is high |
| req_kind | input | 2 | 1 fetch, 2 data read, 3 data write |
| req_addr | input | 16 | Request address |
| req_wdata | input | 8 | Write byte |
| ad_in | input | 8 | Byte read from the shared bus |
| ad_out | output | 8 | Byte driven onto the shared bus |
| ad_oe | output | 1 | Shared-bus drive enable |
| addr_hi | output | 8 | High address byte |
| ale | output | 1 | Address-latch strobe, active high |
| psen_n | output | 1 | Program read strobe, active low |
| rd_n | output | 1 | Data read strobe, active low |
| wr_n | output | 1 | Data write strobe, active low |
| rdata | output | 8 | Last captured byte |
| done | output | 1 | One-clock completion pulse |
| mc_last | output | 1 | Last clock of the machine cycle |

## Verification
The assertions assume that `ale_off` never rises in the middle of an `ale` pulse, so that every falling edge of `ale` comes from the cycle timing. They also assume that requests use only the three defined codes. The bench changes `ale_off` and the request inputs only in the last clock of a machine cycle, or right after it. It changes `fast_mode` only at those points as well, or on purpose in the middle of a cycle when testing R2. The request is withdrawn in the first clock of the new cycle, so every operation is followed by an idle cycle.

// File: rtl/ext_bus_pkg.sv
`timescale 1ns/1ps
// Shared types for the external bus sequencer.
// Assumes a 2-bit request code set by the core.
package ext_bus_pkg;
    typedef enum logic [1:0] {
        BK_IDLE  = 2'd0,
        BK_FETCH = 2'd1,
        BK_READ  = 2'd2,
        BK_WRITE = 2'd3
    } bus_kind_e;
endpackage

// File: rtl/ext_bus_timer.sv
`timescale 1ns/1ps
// Clock-slot timer: counts clocks inside a half machine cycle, tracks
// which half is running and latches the speed select at the cycle
// boundary. Assumes FAST_HALF <= SLOW_HALF.
module ext_bus_timer #(
    parameter int SLOW_HALF = 6,
    parameter int FAST_HALF = 3,
    parameter int SW        = $clog2(SLOW_HALF)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fast_mode,
    output logic [SW-1:0] sub,
    output logic          half,
    output logic          fast_q,
    output logic          mc_last
);
    localparam logic [SW-1:0] SLOW_MAX = SW'(SLOW_HALF - 1);
    localparam logic [SW-1:0] FAST_MAX = SW'(FAST_HALF - 1);

    logic [SW-1:0] sub_max;

    // Last slot index of the current half, chosen by the latched speed.
    always_comb sub_max = fast_q ? FAST_MAX : SLOW_MAX;

    assign mc_last = half && (sub == sub_max);

    // Advance the slot counter, flip halves and latch speed at boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sub    <= '0;
            half   <= 1'b0;
            fast_q <= 1'b0;
        end else if (sub == sub_max) begin
            sub  <= '0;
            half <= ~half;
            if (half) fast_q <= fast_mode;
        end else begin
            sub <= sub + 1'b1;
        end
    end
endmodule

// File: rtl/ext_bus_strobe_dec.sv
`timescale 1ns/1ps
// Strobe decoder: turns the slot position, the latched request and the
// speed into bus strobes, bus drive and capture events. Pure logic.
// Assumes the slot counter never exceeds the half length of the mode.
module ext_bus_strobe_dec
    import ext_bus_pkg::*;
#(
    parameter int AW        = 16,
    parameter int DW        = 8,
    parameter int SLOW_HALF = 6,
    parameter int FAST_HALF = 3,
    parameter int SLOW_ALE  = 2,
    parameter int FAST_ALE  = 1,
    parameter int SW        = $clog2(SLOW_HALF)
) (
    input  bus_kind_e     kind,
    input  logic [SW-1:0] sub,
    input  logic          half,
    input  logic          fast_q,
    input  logic          ale_off,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic          ale,
    output logic          psen_n,
    output logic          rd_n,
    output logic          wr_n,
    output logic          ad_oe,
    output logic [DW-1:0] ad_out,
    output logic [AW-DW-1:0] addr_hi,
    output logic          cap,
    output logic          done_set
);
    localparam logic [SW-1:0] SLOW_MAX = SW'(SLOW_HALF - 1);
    localparam logic [SW-1:0] FAST_MAX = SW'(FAST_HALF - 1);
    localparam logic [SW-1:0] SLOW_AW  = SW'(SLOW_ALE);
    localparam logic [SW-1:0] FAST_AW  = SW'(FAST_ALE);

    logic [SW-1:0] sub_max;
    logic [SW-1:0] ale_w;
    logic          data_cyc;
    logic          ale_slot;
    logic          addr_ph;
    logic          strobe_win;
    logic [AW-1:0] cur_addr;

    // Slot limits for the latched speed.
    always_comb begin
        sub_max = fast_q ? FAST_MAX : SLOW_MAX;
        ale_w   = fast_q ? FAST_AW  : SLOW_AW;
    end

    // Classify the current slot.
    always_comb begin
        data_cyc   = (kind == BK_READ) || (kind == BK_WRITE);
        ale_slot   = !(data_cyc && half);
        addr_ph    = ale_slot && (sub <= ale_w);
        strobe_win = data_cyc &&
                     ((!half && (sub > ale_w)) || (half && (sub < sub_max)));
        cur_addr   = (kind == BK_FETCH && half) ? addr + 1'b1 : addr;
    end

    // Strobe outputs.
    always_comb begin
        ale    = ale_slot && (sub < ale_w) && !ale_off;
        psen_n = !((kind == BK_FETCH) && (sub > ale_w));
        rd_n   = !(strobe_win && (kind == BK_READ));
        wr_n   = !(strobe_win && (kind == BK_WRITE));
    end

    // Shared bus drive: address first, then write data for stores.
    always_comb begin
        addr_hi = cur_addr[AW-1:DW];
        if (addr_ph) begin
            ad_oe  = 1'b1;
            ad_out = cur_addr[DW-1:0];
        end else if (kind == BK_WRITE && (half || (sub > ale_w))) begin
            ad_oe  = 1'b1;
            ad_out = wdata;
        end else begin
            ad_oe  = 1'b0;
            ad_out = '0;
        end
    end

    // Capture and completion events, one clock before the strobe rises.
    always_comb begin
        cap      = ((kind == BK_FETCH) && (sub == sub_max)) ||
                   ((kind == BK_READ) && half && (sub == sub_max - 1'b1));
        done_set = cap ||
                   ((kind == BK_WRITE) && half && (sub == sub_max - 1'b1));
    end
endmodule

// File: rtl/ext_bus_capture.sv
`timescale 1ns/1ps
// Read capture: samples the shared bus on a capture event and issues a
// one-clock completion pulse. Assumes cap implies done_set.
module ext_bus_capture #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cap,
    input  logic          done_set,
    input  logic [DW-1:0] ad_in,
    output logic [DW-1:0] rdata,
    output logic          done
);
    // Hold the last captured byte and register the completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
            done  <= 1'b0;
        end else begin
            if (cap) rdata <= ad_in;
            done <= done_set;
        end
    end
endmodule

// File: rtl/ext_bus_seq.sv
`timescale 1ns/1ps
// External bus cycle sequencer top. Latches a core request at each
// machine-cycle boundary and sequences latch, program, read and write
// strobes over the shared address/data bus. Assumes the core holds its
// request until mc_last.
module ext_bus_seq
    import ext_bus_pkg::*;
#(
    parameter int AW        = 16,
    parameter int DW        = 8,
    parameter int SLOW_HALF = 6,
    parameter int FAST_HALF = 3,
    parameter int SLOW_ALE  = 2,
    parameter int FAST_ALE  = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fast_mode,
    input  logic          ale_off,
    input  logic          req_valid,
    input  logic [1:0]    req_kind,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    input  logic [DW-1:0] ad_in,
    output logic [DW-1:0] ad_out,
    output logic          ad_oe,
    output logic [AW-DW-1:0] addr_hi,
    output logic          ale,
    output logic          psen_n,
    output logic          rd_n,
    output logic          wr_n,
    output logic [DW-1:0] rdata,
    output logic          done,
    output logic          mc_last
);
    localparam int SW = $clog2(SLOW_HALF);

    logic [SW-1:0] sub;
    logic          half;
    logic          fast_q;
    bus_kind_e     kind_q;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] wdata_q;
    logic          cap;
    logic          done_set;

    ext_bus_timer #(
        .SLOW_HALF(SLOW_HALF), .FAST_HALF(FAST_HALF), .SW(SW)
    ) u_timer (
        .clk(clk), .rst_n(rst_n), .fast_mode(fast_mode),
        .sub(sub), .half(half), .fast_q(fast_q), .mc_last(mc_last)
    );

    // Take a new request, or fall back to idle, at each cycle boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kind_q  <= BK_IDLE;
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (mc_last) begin
            kind_q  <= req_valid ? bus_kind_e'(req_kind) : BK_IDLE;
            addr_q  <= req_valid ? req_addr : '0;
            wdata_q <= req_wdata;
        end
    end

    ext_bus_strobe_dec #(
        .AW(AW), .DW(DW), .SLOW_HALF(SLOW_HALF), .FAST_HALF(FAST_HALF),
        .SLOW_ALE(SLOW_ALE), .FAST_ALE(FAST_ALE), .SW(SW)
    ) u_dec (
        .kind(kind_q), .sub(sub), .half(half), .fast_q(fast_q),
        .ale_off(ale_off), .addr(addr_q), .wdata(wdata_q),
        .ale(ale), .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n),
        .ad_oe(ad_oe), .ad_out(ad_out), .addr_hi(addr_hi),
        .cap(cap), .done_set(done_set)
    );

    ext_bus_capture #(.DW(DW)) u_cap (
        .clk(clk), .rst_n(rst_n), .cap(cap), .done_set(done_set),
        .ad_in(ad_in), .rdata(rdata), .done(done)
    );
endmodule

// File: rtl/ext_bus_seq_chk.sv
`timescale 1ns/1ps
// Protocol checker for the bus sequencer, attached by bind. Assumes
// ale_off does not rise in the middle of a latch pulse.
module ext_bus_seq_chk #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ale_off,
    input logic          ale,
    input logic          psen_n,
    input logic          rd_n,
    input logic          wr_n,
    input logic          ad_oe,
    input logic [DW-1:0] ad_out,
    input logic          done
);
    // R6, R7: never read and write at once.
    a_r6_rd_wr_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_n && !wr_n));

    // R5: program strobe stays high during a data strobe.
    a_r5_no_psen_in_data: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_n || !wr_n) |-> psen_n);

    // R9: suppressed latch strobe.
    a_r9_ale_off: assert property (@(posedge clk) disable iff (!rst_n)
        ale_off |-> !ale);

    // R8: address driven while latch strobe is high.
    a_r8_addr_on_ale: assert property (@(posedge clk) disable iff (!rst_n)
        ale |-> ad_oe);

    // R8: address held one clock after latch strobe falls.
    a_r8_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ale) |-> (ad_oe && $stable(ad_out)));

    // R7: write byte held one clock after the write strobe rises.
    a_r7_wr_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_n) |-> (ad_oe && $stable(ad_out)));

    // R4: latch strobe and program strobe never overlap.
    a_r4_psen_no_ale: assert property (@(posedge clk) disable iff (!rst_n)
        !psen_n |-> !ale);

    // R4, R6, R7: completion is a single-clock pulse.
    a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

bind ext_bus_seq ext_bus_seq_chk #(.DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .ale_off(ale_off), .ale(ale),
    .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n), .ad_oe(ad_oe),
    .ad_out(ad_out), .done(done)
);

// File: tb/test_ext_bus_seq.sv
`timescale 1ns/1ps
// Directed bench for the external bus sequencer, with a small external
// memory model that latches the address on the latch strobe.
module test_ext_bus_seq;
    localparam logic [1:0] K_IDLE = 2'd0, K_FETCH = 2'd1,
                           K_READ = 2'd2, K_WRITE = 2'd3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fast_mode = 1'b0;
    logic        ale_off = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_kind = K_IDLE;
    logic [15:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic [7:0]  ad_in = '0;
    logic [7:0]  ad_out;
    logic        ad_oe;
    logic [7:0]  addr_hi;
    logic        ale, psen_n, rd_n, wr_n, done, mc_last;
    logic [7:0]  rdata;

    int n_chk = 0;
    int n_fail = 0;
    logic [15:0] mem_lat = '0;

    always #2.5 clk = ~clk;

    ext_bus_seq i_ext_bus_seq (
        .clk(clk), .rst_n(rst_n), .fast_mode(fast_mode), .ale_off(ale_off),
        .req_valid(req_valid), .req_kind(req_kind), .req_addr(req_addr),
        .req_wdata(req_wdata), .ad_in(ad_in), .ad_out(ad_out), .ad_oe(ad_oe),
        .addr_hi(addr_hi), .ale(ale), .psen_n(psen_n), .rd_n(rd_n),
        .wr_n(wr_n), .rdata(rdata), .done(done), .mc_last(mc_last)
    );

    function automatic logic [7:0] mem_f(input logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h5A;
    endfunction

    // External memory model: latch on the strobe, return a derived byte.
    always @(negedge clk) begin
        if (ale) mem_lat = {addr_hi, ad_out};
        ad_in = mem_f(mem_lat);
    end

    task automatic chk(input bit ok, input string req, input int act,
                       input int exp, input int idx);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s clk %0d: actual 0x%0h expected 0x%0h",
                     req, idx, act, exp);
        end
    endtask

    task automatic wait_boundary();
        do @(negedge clk); while (!mc_last);
    endtask

    task automatic set_mode(input bit f);
        wait_boundary();
        fast_mode = f;
        wait_boundary();
    endtask

    // Issue one request at a boundary and check every clock of its cycle.
    task automatic run_op(input logic [1:0] k, input logic [15:0] a,
                          input logic [7:0] wd, input bit fm,
                          input bit aoff, input string tag);
        int hl, aw, L;
        hl = fm ? 3 : 6;
        aw = fm ? 1 : 2;
        L  = 2 * hl;
        wait_boundary();
        req_valid = (k != K_IDLE);
        req_kind  = k;
        req_addr  = a;
        req_wdata = wd;
        ale_off   = aoff;
        for (int i = 0; i <= L; i++) begin
            int s;
            bit h, dc, slot, win, e_oe, e_done;
            logic [4:0] e_vec, a_vec;
            logic [15:0] cur;
            logic [7:0] e_ad;
            @(negedge clk);
            if (i == 0) req_valid = 1'b0;
            if (i < L) begin
                s    = i % hl;
                h    = (i >= hl);
                dc   = (k == K_READ) || (k == K_WRITE);
                slot = !(dc && h);
                win  = dc && ((!h && s > aw) || (h && s < hl - 1));
                cur  = (k == K_FETCH && h) ? a + 16'd1 : a;
                e_vec = {!aoff && slot && s < aw,
                         !(k == K_FETCH && s > aw),
                         !(win && k == K_READ),
                         !(win && k == K_WRITE),
                         i == L - 1};
                a_vec = {ale, psen_n, rd_n, wr_n, mc_last};
                chk(a_vec[4:3] == e_vec[4:3],
                    aoff ? "R9" : (dc ? "R5" : tag),
                    int'(a_vec[4:3]), int'(e_vec[4:3]), i);
                chk(a_vec[2:0] == e_vec[2:0], tag,
                    int'(a_vec[2:0]), int'(e_vec[2:0]), i);
                if (slot && s <= aw) begin
                    e_oe = 1'b1; e_ad = cur[7:0];
                end else if (k == K_WRITE && (h || s > aw)) begin
                    e_oe = 1'b1; e_ad = wd;
                end else begin
                    e_oe = 1'b0; e_ad = 8'h00;
                end
                chk(ad_oe == e_oe && (!e_oe || ad_out == e_ad),
                    (k == K_WRITE && !(slot && s <= aw)) ? "R7" : "R8",
                    int'({ad_oe, ad_out}), int'({e_oe, e_ad}), i);
                chk(addr_hi == cur[15:8], "R8", int'(addr_hi),
                    int'(cur[15:8]), i);
            end
            e_done = (k == K_FETCH && (i == hl || i == L)) ||
                     ((k == K_READ || k == K_WRITE) && i == L - 1);
            chk(done == e_done, tag, int'(done), int'(e_done), i);
            if (e_done && k != K_WRITE && !aoff)
                chk(rdata == mem_f((k == K_FETCH && i == L) ? a + 16'd1 : a),
                    tag, int'(rdata),
                    int'(mem_f((k == K_FETCH && i == L) ? a + 16'd1 : a)), i);
        end
        ale_off = 1'b0;
    endtask

    task automatic t_reset();
        int n;
        @(negedge clk);
        chk({rd_n, wr_n, psen_n, done} == 4'b1110 && rdata == 8'h00, "R10",
            int'({rd_n, wr_n, psen_n, done, rdata}), 'he00, 0);
        wait_boundary();
        n = 0;
        do begin @(negedge clk); n++; end while (!mc_last);
        chk(n == 12, "R10", n, 12, 0);
    endtask

    // R1, R2: a mid-cycle speed change waits for the boundary.
    task automatic t_mode_switch();
        int n;
        wait_boundary();
        @(negedge clk);
        fast_mode = 1'b1;
        n = 1;
        do begin @(negedge clk); n++; end while (!mc_last);
        chk(n == 12, "R2", n, 12, 0);
        n = 0;
        do begin @(negedge clk); n++; end while (!mc_last);
        chk(n == 6, "R1", n, 6, 0);
        fast_mode = 1'b0;
        n = 0;
        do begin @(negedge clk); n++; end while (!mc_last);
        chk(n == 12, "R1", n, 12, 0);
    endtask

    // R11: a request withdrawn before the boundary is ignored.
    task automatic t_ignored_req();
        bit ok;
        wait_boundary();
        @(negedge clk);
        req_valid = 1'b1; req_kind = K_FETCH; req_addr = 16'h4321;
        @(negedge clk);
        req_valid = 1'b0;
        ok = 1'b1;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (!psen_n || done) ok = 1'b0;
        end
        chk(ok, "R11", int'(ok), 1, 0);
    endtask

    initial begin
        #(5.0 * 150000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures",
                 n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        run_op(K_IDLE,  16'h0000, 8'h00, 1'b0, 1'b0, "R3");
        run_op(K_FETCH, 16'h1234, 8'h00, 1'b0, 1'b0, "R4");
        run_op(K_READ,  16'hA55A, 8'h00, 1'b0, 1'b0, "R6");
        run_op(K_WRITE, 16'h8001, 8'hC3, 1'b0, 1'b0, "R7");
        t_mode_switch();
        set_mode(1'b1);
        run_op(K_IDLE,  16'h0000, 8'h00, 1'b1, 1'b0, "R3");
        run_op(K_FETCH, 16'h12FF, 8'h00, 1'b1, 1'b0, "R4");
        run_op(K_READ,  16'h00FE, 8'h00, 1'b1, 1'b0, "R6");
        run_op(K_WRITE, 16'hFFFF, 8'h3C, 1'b1, 1'b0, "R7");
        set_mode(1'b0);
        run_op(K_FETCH, 16'h0F0F, 8'h00, 1'b0, 1'b1, "R9");
        run_op(K_READ,  16'h7E81, 8'h00, 1'b0, 1'b1, "R9");
        t_ignored_req();
        $display("End of test - %0d assertions evaluated, %0d failures",
                 n_chk, n_fail);
        $finish;
    end
endmodule